// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block derives two banks of output clocks, A and B, plus a reference-rate clock, from a single master clock that runs at twelve times the reference frequency. Each bank carries five phase-aligned copies of one divider output. A bank runs at one, two, three or four times the reference rate, selected by its own 2-bit rate code. The two codes and the spread-enable decision come either from dedicated pins or from a control register byte, and a register bit chooses which source applies.

A test setting in the same control byte forces fixed slow rates on both banks. A rate change is held off until the running output period finishes, so no shortened high or low phase reaches a bank. For the divide-by-three case, a flop on the falling master edge provides the extra half cycle that keeps the duty cycle at 50 percent. Each bank has an active-high output enable, and driving it low withdraws the bank. This is modelled as a drive-valid flag for the pad ring. The block also produces the spread-enable decision but does no modulation of its own.

Top module: `dual_bank_clkgen`

## Requirements
- R1: A bank's 2-bit rate code selects the divide ratio of the master clock: code 00 gives /12 (1x reference), 01 gives /6 (2x), 10 gives /4 (3x), and 11 gives /3 (4x).
- R2: Bank A and bank B each follow only their own rate code, so the two banks can run at different rates at the same time.
- R3: When `ctl_reg[0]` is 1, the rate codes come from `pin_code_a` and `pin_code_b`. When it is 0, bank A uses `ctl_reg[2:1]` and bank B uses `ctl_reg[4:3]`. Bit 1 and bit 3 are the LSBs of these fields.
- R4: `spread_en` is high when `ctl_reg[0]`=1 and `spread_pin_n` is low, or when `ctl_reg[0]`=0 and `ctl_reg[6]` is 1. It is low in every other case.
- R5: When `ctl_reg[7]` is 0 (test), bank A divides the master clock by 72 and bank B by 48, whatever the rate codes are. `ref_clk` is not affected.
- R6: `bank_a_drive` equals `oe_a` and `bank_b_drive` equals `oe_b`, with no delay. `ref_drive` is high only when both enables are high.
- R7: Every output clock is high for exactly half of its period, measured in half master cycles. This includes the divide-by-3 rate, which is high for 1.5 master cycles.
- R8: A new ratio is taken only at the master edge that ends the current output period. Each period is therefore emitted complete at the ratio that was in force when it started.
- R9: All five clocks of a bank are identical at all times.
- R10: `ref_clk` always divides the master clock by 12.
- R11: While `rst_n` is low, all clock outputs are low. The first master rising edge after release starts a new high phase on every output, using the ratio selected at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 12x the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_code_a | input | 2 | Pin-sourced rate code for bank A |
| pin_code_b | input | 2 | Pin-sourced rate code for bank B |
| spread_pin_n | input | 1 | Pin-sourced spread request, active low |
| ctl_reg | input | 8 | Control byte: [7] run/test, [6] spread, [5] spread width, [4:3] B code, [2:1] A code, [0] pin source |
| oe_a | input | 1 | Bank A output enable |
| oe_b | input | 1 | Bank B output enable |
| bank_a_clk | output | 5 | Bank A clocks |
| bank_b_clk | output | 5 | Bank B clocks |
| ref_clk | output | 1 | Reference-rate clock |
| bank_a_drive | output | 1 | Bank A pads driven |
| bank_b_drive | output | 1 | Bank B pads driven |
| ref_drive | output | 1 | Reference pad driven |
| spread_en | output | 1 | Resolved spread-enable decision |

## Verification
The bench samples every output twice per master cycle, once in each half, so the half-cycle extension of the divide-by-3 rate is visible. A divider without the falling-edge flop would show a 1-of-3 or 2-of-3 duty and miss the expected value in the second half. Rate codes are changed in the middle of periods and across odd and even ratios. A design that reloads the ratio immediately would cut a period short and fall out of step with the reference model. Register mode is run with pin codes that differ from the register fields, so a source multiplexer that is swapped or stuck shows up as the wrong bank rate. Test mode is entered and left while both banks are running, and a reset is applied in the middle of a run to confirm that every output restarts in phase.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // Control byte layout; field positions are decoded by the register file.
    typedef struct packed {
        logic       test_n;       // 1 = run, 0 = fixed test ratios
        logic       spread_on;    // register spread request, active high
        logic       spread_half;  // spread width choice, consumed elsewhere
        logic [1:0] code_b;
        logic [1:0] code_a;
        logic       pin_mode;     // 1 = codes and spread from pins
    } ctl_t;

    // Master cycles per output period for a rate code.
    function automatic int code_ratio(input int mult, input logic [1:0] code);
        case (code)
            2'd0:    return mult;
            2'd1:    return mult / 2;
            2'd2:    return mult / 3;
            default: return mult / 4;
        endcase
    endfunction

endpackage

// File: rtl/bank_rate_sel.sv
module bank_rate_sel
    import clkgen_pkg::*;
#(
    parameter int MULT   = 12,
    parameter int TEST_A = 6,
    parameter int TEST_B = 4,
    parameter int CNT_W  = 7
) (
    input  logic [1:0]       pin_code_a,
    input  logic [1:0]       pin_code_b,
    input  logic             spread_pin_n,
    input  ctl_t             ctl,
    output logic [CNT_W-1:0] ratio_a,
    output logic [CNT_W-1:0] ratio_b,
    output logic             spread_en
);

    logic [1:0] code_a;
    logic [1:0] code_b;
    logic       unused_width;

    assign unused_width = ctl.spread_half;

    always_comb begin
        code_a    = ctl.pin_mode ? pin_code_a : ctl.code_a;
        code_b    = ctl.pin_mode ? pin_code_b : ctl.code_b;
        spread_en = ctl.pin_mode ? ~spread_pin_n : ctl.spread_on;
        if (!ctl.test_n) begin
            ratio_a = CNT_W'(MULT * TEST_A);
            ratio_b = CNT_W'(MULT * TEST_B);
        end else begin
            ratio_a = CNT_W'(code_ratio(MULT, code_a));
            ratio_b = CNT_W'(code_ratio(MULT, code_b));
        end
    end

endmodule

// File: rtl/bank_divider.sv
module bank_divider #(
    parameter int CNT_W     = 7,
    parameter int RST_RATIO = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             div_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
        logic             hi;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    wrap;
    logic    lo_q;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt >= st_q.ratio - 1'b1);
        if (wrap) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.hi = (st_d.cnt < (st_d.ratio >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '1;
            st_q.ratio <= CNT_W'(RST_RATIO);
            st_q.hi    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Half-cycle extension for odd ratios
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) lo_q <= 1'b0;
        else        lo_q <= st_q.hi;
    end

    assign div_o = st_q.hi | (st_q.ratio[0] & lo_q);

endmodule

// File: rtl/dual_bank_clkgen.sv
module dual_bank_clkgen
    import clkgen_pkg::*;
#(
    parameter int MULT    = 12,
    parameter int TEST_A  = 6,
    parameter int TEST_B  = 4,
    parameter int NUM_OUT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pin_code_a,
    input  logic [1:0]         pin_code_b,
    input  logic               spread_pin_n,
    input  logic [7:0]         ctl_reg,
    input  logic               oe_a,
    input  logic               oe_b,
    output logic [NUM_OUT-1:0] bank_a_clk,
    output logic [NUM_OUT-1:0] bank_b_clk,
    output logic               ref_clk,
    output logic               bank_a_drive,
    output logic               bank_b_drive,
    output logic               ref_drive,
    output logic               spread_en
);

    localparam int MAX_RATIO = MULT * ((TEST_A > TEST_B) ? TEST_A : TEST_B);
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);
    localparam int NUM_BANKS = 2;

    logic [CNT_W-1:0]     ratio [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_tick;

    bank_rate_sel #(
        .MULT   (MULT),
        .TEST_A (TEST_A),
        .TEST_B (TEST_B),
        .CNT_W  (CNT_W)
    ) u_sel (
        .pin_code_a   (pin_code_a),
        .pin_code_b   (pin_code_b),
        .spread_pin_n (spread_pin_n),
        .ctl          (ctl_t'(ctl_reg)),
        .ratio_a      (ratio[0]),
        .ratio_b      (ratio[1]),
        .spread_en    (spread_en)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_divider #(
            .CNT_W     (CNT_W),
            .RST_RATIO (MULT)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .ratio_i (ratio[b]),
            .div_o   (bank_tick[b])
        );
    end

    bank_divider #(
        .CNT_W     (CNT_W),
        .RST_RATIO (MULT)
    ) u_ref_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (CNT_W'(MULT)),
        .div_o   (ref_clk)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_fan
        assign bank_a_clk[i] = bank_tick[0];
        assign bank_b_clk[i] = bank_tick[1];
    end

    assign bank_a_drive = oe_a;
    assign bank_b_drive = oe_b;
    assign ref_drive    = oe_a & oe_b;

endmodule

// File: rtl/dual_bank_clkgen_chk.sv
module dual_bank_clkgen_chk #(
    parameter int MULT   = 12,
    parameter int TEST_A = 6,
    parameter int TEST_B = 4
) (
    input logic clk,
    input logic rst_n,
    input logic pin_mode,
    input logic spread_pin_n,
    input logic clk_a0,
    input logic clk_b0,
    input logic ref_clk,
    input logic bank_a_drive,
    input logic bank_b_drive,
    input logic ref_drive,
    input logic spread_en
);

    logic [7:0] gap_a_q, gap_b_q, gap_r_q;
    logic       prev_a_q, prev_b_q, prev_r_q;
    logic       seen_a_q, seen_b_q, seen_r_q;
    logic       rise_a, rise_b, rise_r;

    assign rise_a = clk_a0 & ~prev_a_q;
    assign rise_b = clk_b0 & ~prev_b_q;
    assign rise_r = ref_clk & ~prev_r_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_a_q  <= '0;
            gap_b_q  <= '0;
            gap_r_q  <= '0;
            prev_a_q <= 1'b0;
            prev_b_q <= 1'b0;
            prev_r_q <= 1'b0;
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
            seen_r_q <= 1'b0;
        end else begin
            prev_a_q <= clk_a0;
            prev_b_q <= clk_b0;
            prev_r_q <= ref_clk;
            seen_a_q <= seen_a_q | rise_a;
            seen_b_q <= seen_b_q | rise_b;
            seen_r_q <= seen_r_q | rise_r;
            gap_a_q  <= rise_a ? 8'd1 : ((gap_a_q == 8'hff) ? gap_a_q : gap_a_q + 8'd1);
            gap_b_q  <= rise_b ? 8'd1 : ((gap_b_q == 8'hff) ? gap_b_q : gap_b_q + 8'd1);
            gap_r_q  <= rise_r ? 8'd1 : ((gap_r_q == 8'hff) ? gap_r_q : gap_r_q + 8'd1);
        end
    end

    // R6
    ref_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_drive == (bank_a_drive && bank_b_drive));

    // R4
    spread_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && !spread_pin_n) |-> spread_en);

    // R8
    period_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_a && seen_a_q) |-> (gap_a_q == 8'(MULT) || gap_a_q == 8'(MULT/2) ||
            gap_a_q == 8'(MULT/3) || gap_a_q == 8'(MULT/4) || gap_a_q == 8'(MULT*TEST_A)));

    // R8
    period_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_b && seen_b_q) |-> (gap_b_q == 8'(MULT) || gap_b_q == 8'(MULT/2) ||
            gap_b_q == 8'(MULT/3) || gap_b_q == 8'(MULT/4) || gap_b_q == 8'(MULT*TEST_B)));

    // R10
    ref_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_r && seen_r_q) |-> (gap_r_q == 8'(MULT)));

endmodule

bind dual_bank_clkgen dual_bank_clkgen_chk #(
    .MULT   (MULT),
    .TEST_A (TEST_A),
    .TEST_B (TEST_B)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_mode     (ctl_reg[0]),
    .spread_pin_n (spread_pin_n),
    .clk_a0       (bank_a_clk[0]),
    .clk_b0       (bank_b_clk[0]),
    .ref_clk      (ref_clk),
    .bank_a_drive (bank_a_drive),
    .bank_b_drive (bank_b_drive),
    .ref_drive    (ref_drive),
    .spread_en    (spread_en)
);

// File: tb/dual_bank_clkgen_bench.sv
`timescale 1ns/1ps
module dual_bank_clkgen_bench;

    localparam real CLK_PERIOD = 5.0;
    localparam int  MULT       = 12;
    localparam int  NUM_OUT    = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         pin_code_a = 2'b00;
    logic [1:0]         pin_code_b = 2'b00;
    logic               spread_pin_n = 1'b1;
    logic [7:0]         ctl_reg = 8'hA1;
    logic               oe_a = 1'b1;
    logic               oe_b = 1'b1;
    logic [NUM_OUT-1:0] bank_a_clk, bank_b_clk;
    logic               ref_clk, bank_a_drive, bank_b_drive, ref_drive, spread_en;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string phase_tag = "R11";

    // reference model state
    int ca = 0, cb = 0, cr = 0;
    int na = MULT, nb = MULT, nr = MULT;
    bit first = 1'b1;
    bit live  = 1'b0;

    dual_bank_clkgen u_dual_bank_clkgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_code_a   (pin_code_a),
        .pin_code_b   (pin_code_b),
        .spread_pin_n (spread_pin_n),
        .ctl_reg      (ctl_reg),
        .oe_a         (oe_a),
        .oe_b         (oe_b),
        .bank_a_clk   (bank_a_clk),
        .bank_b_clk   (bank_b_clk),
        .ref_clk      (ref_clk),
        .bank_a_drive (bank_a_drive),
        .bank_b_drive (bank_b_drive),
        .ref_drive    (ref_drive),
        .spread_en    (spread_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int rate_of(input logic [1:0] code);
        return MULT / (int'(code) + 1);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input int half);
        logic ea, eb, er, es;
        ea = live && ((2*ca + half) < na);
        eb = live && ((2*cb + half) < nb);
        er = live && ((2*cr + half) < nr);
        es = ctl_reg[0] ? ~spread_pin_n : ctl_reg[6];
        check(phase_tag, "bank A clocks", 32'(bank_a_clk), 32'({NUM_OUT{ea}}));
        check(phase_tag, "bank B clocks", 32'(bank_b_clk), 32'({NUM_OUT{eb}}));
        check("R10", "ref clock", 32'(ref_clk), 32'(er));
        check("R9", "bank A copies equal", 32'(bank_a_clk == {NUM_OUT{bank_a_clk[0]}}), 32'd1);
        check("R6", "drive flags", 32'({bank_a_drive, bank_b_drive, ref_drive}),
              32'({oe_a, oe_b, oe_a & oe_b}));
        check("R4", "spread decision", 32'(spread_en), 32'(es));
    endtask

    // behavioural model advanced on each master rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            first = 1'b1;
            live  = 1'b0;
        end else begin
            logic [1:0] code_a, code_b;
            int         ta, tb;
            code_a = ctl_reg[0] ? pin_code_a : ctl_reg[2:1];
            code_b = ctl_reg[0] ? pin_code_b : ctl_reg[4:3];
            ta = ctl_reg[7] ? rate_of(code_a) : MULT * 6;
            tb = ctl_reg[7] ? rate_of(code_b) : MULT * 4;
            if (first || ca == na - 1) begin ca = 0; na = ta; end else ca++;
            if (first || cb == nb - 1) begin cb = 0; nb = tb; end else cb++;
            if (first || cr == nr - 1) begin cr = 0; nr = MULT; end else cr++;
            first = 1'b0;
            live  = 1'b1;
        end
        #(CLK_PERIOD/4);
        compare(0);
        #(CLK_PERIOD/2);
        compare(1);
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R11: reset state, then first period after release
        phase_tag = "R11";
        run(5);
        rst_n = 1'b1;
        run(30);

        // R1: every pin code on bank A
        phase_tag = "R1";
        pin_code_a = 2'b01; run(40);
        pin_code_a = 2'b10; run(40);
        pin_code_a = 2'b11; pin_code_b = 2'b11; run(40);

        // R2: banks at different rates together
        phase_tag = "R2";
        pin_code_a = 2'b00; pin_code_b = 2'b11; run(50);
        pin_code_a = 2'b10; pin_code_b = 2'b01; run(50);

        // R7: odd ratio duty on both banks
        phase_tag = "R7";
        pin_code_a = 2'b11; pin_code_b = 2'b11; run(30);

        // R8: codes changed in the middle of periods
        phase_tag = "R8";
        for (int k = 0; k < 12; k++) begin
            pin_code_a = 2'(k);
            pin_code_b = 2'(k + 2);
            run(5 + (k % 4));
        end
        run(30);

        // R3: register source, pins set to conflicting values
        phase_tag = "R3";
        pin_code_a = 2'b11; pin_code_b = 2'b11;
        ctl_reg = 8'hAC; run(40);
        ctl_reg = 8'hEC; spread_pin_n = 1'b0; run(20);
        ctl_reg = 8'hA1; run(30);

        // R4: pin spread request, then register spread ignored in pin mode
        phase_tag = "R4";
        spread_pin_n = 1'b1; run(5);
        ctl_reg = 8'hE1; run(5);
        spread_pin_n = 1'b0; run(5);

        // R5: test ratios override the codes
        phase_tag = "R5";
        pin_code_a = 2'b01; pin_code_b = 2'b10;
        ctl_reg = 8'h21; run(300);
        ctl_reg = 8'hA1; run(100);

        // R6: enables
        phase_tag = "R6";
        oe_a = 1'b0; run(10);
        oe_b = 1'b0; run(10);
        oe_a = 1'b1; run(10);
        oe_b = 1'b1; run(10);

        // R11: reset in the middle of a run
        phase_tag = "R11";
        pin_code_a = 2'b11; pin_code_b = 2'b10;
        @(posedge clk); #4;
        rst_n = 1'b0;
        run(4);
        rst_n = 1'b1;
        run(40);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule